// File: doc/BRIEF.md
# Vectored Priority Interrupt Sequencer

This block decides when a processor takes an interrupt from bus devices and performs the whole entry and exit sequence for it. Devices raise requests on four priority levels. Each level has one shared request line and one grant line. The grant passes serially from device slot to device slot. Between instructions the block compares the pending levels with the priority field of the current status word. It opens the grant on the best level and waits for the device that took the grant to return a vector address. It then saves the old context on the stack, pulls the new program counter and status word from the vector block, and presents the new context to the processor in a single load pulse.

If a grant goes unanswered for a fixed number of cycles, the block abandons it and signals a spurious interrupt. It then enters a handler through a fixed vector address. A return request reverses the entry sequence: it reloads the saved counter and status from the stack and releases the stack space. Requests are level-sensitive. A request that is not served stays visible and is taken as soon as the priority rules allow it.

The processor supplies its current counter, status word and stack pointer. It asserts the boundary input when an interrupt may be taken. All stack and vector traffic goes through a simple request/acknowledge memory port.

Top module: `vec_irq_unit`

## Requirements
- R1: With the block idle and the boundary input high, level L (0..3, priority value 4+L) is eligible only if at least one of its slots requests and 4+L is strictly greater than the status field cpuPsw[7:5]. With the boundary input low, nothing is granted.
- R2: When several levels are eligible, the numerically highest level receives the grant.
- R3: Slot index is level*4+position. Within the granted level, only the requesting slot at the lowest position receives the grant. At most one slotGrant bit is high at any time, and only for a slot that requests.
- R4: The grant stays open until vecValid is seen. Bits [1:0] of the captured vector are forced to zero. vecValid has no effect while no grant is open.
- R5: On entry, the old status word is written to sp-2 first and the old counter to sp-4 after it.
- R6: The new counter is read from the vector and the new status word from vector+2. ctxLoad is a one-cycle pulse carrying these values with newSp = sp-4.
- R7: After 64 grant cycles without a vector, spuriousEvt pulses once and the handler is entered through vector 0x0010.
- R8: A return request (taking precedence over interrupts) reads the counter from sp and the status word from sp+2, and loads them with newSp = sp+4.
- R9: A request left asserted is granted again once the status priority allows it, with no new edge needed.
- R10: memReq, memWrite, memAddr and memWdata stay unchanged until memAck is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cpuBoundary | input | 1 | Processor is at an instruction boundary |
| rtiReq | input | 1 | Return-from-interrupt request |
| cpuPc | input | 16 | Current program counter |
| cpuPsw | input | 16 | Current status word, priority in bits 7:5 |
| cpuSp | input | 16 | Current stack pointer |
| slotReq | input | 16 | Per-slot requests, index level*4+position |
| slotGrant | output | 16 | Per-slot grant after the serial chain |
| vecValid | input | 1 | Granted device presents its vector |
| vecAddr | input | 16 | Vector address from the device |
| memReq | output | 1 | Memory access request |
| memWrite | output | 1 | Access is a write |
| memAddr | output | 16 | Byte address of the access |
| memWdata | output | 16 | Write data |
| memAck | input | 1 | Access complete, read data valid |
| memRdata | input | 16 | Read data |
| ctxLoad | output | 1 | New context valid for one cycle |
| newPc | output | 16 | Counter to load |
| newPsw | output | 16 | Status word to load |
| newSp | output | 16 | Stack pointer to load |
| spuriousEvt | output | 1 | Unanswered grant was abandoned |
| busy | output | 1 | A sequence is in progress |

## Verification
Most internal faults show first on the grant pins. A wrong level or slot choice puts a grant on a slot the bench did not expect in the cycle after the request is seen. A wrong priority comparison opens a grant the status word should have blocked. Errors in the saved or fetched context, the stack offsets or the vector masking show at the next ctxLoad pulse, a few memory handshakes later, as a mismatched counter, status or stack pointer, or as wrong words left on the stack. A timer fault shows as a grant window that is shorter or longer than 64 cycles, or as a missing spurious pulse.

// File: rtl/vip_pkg.sv
package vip_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_GRANT,
    ST_PUSH_PSW,
    ST_PUSH_PC,
    ST_FETCH_PC,
    ST_FETCH_PSW,
    ST_RTI_PC,
    ST_RTI_PSW,
    ST_DONE
  } ctrlState_t;

  typedef enum logic [2:0] {
    ADR_STK_PSW,
    ADR_STK_PC,
    ADR_VEC,
    ADR_VEC_HI,
    ADR_SP,
    ADR_SP_HI
  } addrSel_t;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic     captureCtx;
    logic     captureRti;
    logic     captureVec;
    logic     useSpur;
    logic     timerClr;
    logic     timerRun;
    logic     loadPc;
    logic     loadPsw;
    logic     memReq;
    logic     memWrite;
    addrSel_t addrSel;
  } strobe_t;

endpackage

// File: rtl/vip_chain.sv
// Serial grant chain of one level: a slot that requests consumes the grant,
// a quiet slot passes it to the next position.
module vip_chain #(
  parameter int SLOTS = 4
) (
  input  logic             grantIn,
  input  logic [SLOTS-1:0] reqIn,
  output logic [SLOTS-1:0] grantOut
);
  logic [SLOTS-1:0] passIn;

  assign passIn[0] = grantIn;

  for (genvar k = 0; k < SLOTS; k++) begin : g_slot
    assign grantOut[k] = passIn[k] & reqIn[k];
    if (k < SLOTS - 1) begin : g_pass
      assign passIn[k+1] = passIn[k] & ~reqIn[k];
    end
  end
endmodule

// File: rtl/vip_arbiter.sv
// Wired level requests, strict priority comparison and highest-level pick.
module vip_arbiter #(
  parameter int LEVELS    = 4,
  parameter int SLOTS     = 4,
  parameter int PRIO_W    = 3,
  parameter int PRIO_BASE = 4,
  localparam int NSLOT    = LEVELS * SLOTS,
  localparam int LW       = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
  input  logic [NSLOT-1:0]  slotReq,
  input  logic [PRIO_W-1:0] pswPrio,
  output logic              anyEligible,
  output logic [LW-1:0]     winLevel
);
  logic [LEVELS-1:0] levelReq;
  logic [LEVELS-1:0] eligible;

  for (genvar l = 0; l < LEVELS; l++) begin : g_level
    assign levelReq[l] = |slotReq[l*SLOTS +: SLOTS];
    assign eligible[l] = levelReq[l] && ((PRIO_BASE + l) > int'(pswPrio));
  end

  always_comb begin
    anyEligible = 1'b0;
    winLevel    = '0;
    for (int l = 0; l < LEVELS; l++) begin
      if (eligible[l]) begin
        anyEligible = 1'b1;
        winLevel    = LW'(l);
      end
    end
  end
endmodule

// File: rtl/vip_ctrl.sv
// Sequencer: grant, stack push, vector fetch, return, context load.
module vip_ctrl
  import vip_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    cpuBoundary,
  input  logic    rtiReq,
  input  logic    anyEligible,
  input  logic    vecValid,
  input  logic    timeoutHit,
  input  logic    memAck,
  output strobe_t stb,
  output logic    grantActive,
  output logic    ctxLoad,
  output logic    busy
);
  ctrlState_t state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stb       = '0;
    stateNext = state;
    unique case (state)
      ST_IDLE: begin
        if (rtiReq) begin
          stb.captureCtx = 1'b1;
          stb.captureRti = 1'b1;
          stateNext      = ST_RTI_PC;
        end else if (cpuBoundary && anyEligible) begin
          stb.captureCtx = 1'b1;
          stb.timerClr   = 1'b1;
          stateNext      = ST_GRANT;
        end
      end
      ST_GRANT: begin
        stb.timerRun = 1'b1;
        if (vecValid) begin
          stb.captureVec = 1'b1;
          stateNext      = ST_PUSH_PSW;
        end else if (timeoutHit) begin
          stb.captureVec = 1'b1;
          stb.useSpur    = 1'b1;
          stateNext      = ST_PUSH_PSW;
        end
      end
      ST_PUSH_PSW: begin
        stb.memReq   = 1'b1;
        stb.memWrite = 1'b1;
        stb.addrSel  = ADR_STK_PSW;
        if (memAck) stateNext = ST_PUSH_PC;
      end
      ST_PUSH_PC: begin
        stb.memReq   = 1'b1;
        stb.memWrite = 1'b1;
        stb.addrSel  = ADR_STK_PC;
        if (memAck) stateNext = ST_FETCH_PC;
      end
      ST_FETCH_PC: begin
        stb.memReq  = 1'b1;
        stb.addrSel = ADR_VEC;
        if (memAck) begin
          stb.loadPc = 1'b1;
          stateNext  = ST_FETCH_PSW;
        end
      end
      ST_FETCH_PSW: begin
        stb.memReq  = 1'b1;
        stb.addrSel = ADR_VEC_HI;
        if (memAck) begin
          stb.loadPsw = 1'b1;
          stateNext   = ST_DONE;
        end
      end
      ST_RTI_PC: begin
        stb.memReq  = 1'b1;
        stb.addrSel = ADR_SP;
        if (memAck) begin
          stb.loadPc = 1'b1;
          stateNext  = ST_RTI_PSW;
        end
      end
      ST_RTI_PSW: begin
        stb.memReq  = 1'b1;
        stb.addrSel = ADR_SP_HI;
        if (memAck) begin
          stb.loadPsw = 1'b1;
          stateNext   = ST_DONE;
        end
      end
      ST_DONE: stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  assign grantActive = (state == ST_GRANT);
  assign ctxLoad     = (state == ST_DONE);
  assign busy        = (state != ST_IDLE);
endmodule

// File: rtl/vip_dpath.sv
// Context registers, vector capture, grant timer and memory port muxing.
module vip_dpath
  import vip_pkg::*;
#(
  parameter int             DW       = 16,
  parameter int             LW       = 2,
  parameter int             TIMEOUT  = 64,
  parameter logic [DW-1:0]  SPUR_VEC = 16'h0010,
  localparam int            TW       = $clog2(TIMEOUT + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  strobe_t       stb,
  input  logic [DW-1:0] cpuPc,
  input  logic [DW-1:0] cpuPsw,
  input  logic [DW-1:0] cpuSp,
  input  logic [LW-1:0] winLevel,
  input  logic [DW-1:0] vecAddr,
  input  logic [DW-1:0] memRdata,
  output logic [LW-1:0] grantLevel,
  output logic          timeoutHit,
  output logic          spurFlag,
  output logic          memReq,
  output logic          memWrite,
  output logic [DW-1:0] memAddr,
  output logic [DW-1:0] memWdata,
  output logic [DW-1:0] newPc,
  output logic [DW-1:0] newPsw,
  output logic [DW-1:0] newSp
);
  localparam logic [DW-1:0] WORD  = DW'(2);
  localparam logic [DW-1:0] FRAME = DW'(4);

  logic [DW-1:0] savedPc, savedPsw, baseSp, vecReg, pcReg, pswReg;
  logic          rtiMode;
  logic [TW-1:0] timer;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      savedPc    <= '0;
      savedPsw   <= '0;
      baseSp     <= '0;
      rtiMode    <= 1'b0;
      grantLevel <= '0;
      timer      <= '0;
      vecReg     <= '0;
      spurFlag   <= 1'b0;
      pcReg      <= '0;
      pswReg     <= '0;
    end else begin
      if (stb.captureCtx) begin
        savedPc    <= cpuPc;
        savedPsw   <= cpuPsw;
        baseSp     <= cpuSp;
        rtiMode    <= stb.captureRti;
        grantLevel <= winLevel;
      end
      if (stb.timerClr)
        timer <= '0;
      else if (stb.timerRun && !timeoutHit)
        timer <= timer + TW'(1);
      if (stb.captureVec)
        vecReg <= stb.useSpur ? SPUR_VEC : {vecAddr[DW-1:2], 2'b00};
      spurFlag <= stb.captureVec && stb.useSpur;
      if (stb.loadPc)  pcReg  <= memRdata;
      if (stb.loadPsw) pswReg <= memRdata;
    end
  end

  assign timeoutHit = (timer == TW'(TIMEOUT - 1));

  always_comb begin
    memWdata = savedPsw;
    unique case (stb.addrSel)
      ADR_STK_PSW: memAddr = baseSp - WORD;
      ADR_STK_PC: begin
        memAddr  = baseSp - FRAME;
        memWdata = savedPc;
      end
      ADR_VEC:    memAddr = vecReg;
      ADR_VEC_HI: memAddr = vecReg + WORD;
      ADR_SP:     memAddr = baseSp;
      ADR_SP_HI:  memAddr = baseSp + WORD;
      default:    memAddr = baseSp;
    endcase
  end

  assign memReq   = stb.memReq;
  assign memWrite = stb.memWrite;
  assign newPc    = pcReg;
  assign newPsw   = pswReg;
  assign newSp    = rtiMode ? (baseSp + FRAME) : (baseSp - FRAME);
endmodule

// File: rtl/vec_irq_unit.sv
module vec_irq_unit
  import vip_pkg::*;
#(
  parameter int            DW        = 16,
  parameter int            LEVELS    = 4,
  parameter int            SLOTS     = 4,
  parameter int            PRIO_LSB  = 5,
  parameter int            PRIO_W    = 3,
  parameter int            PRIO_BASE = 4,
  parameter int            TIMEOUT   = 64,
  parameter logic [DW-1:0] SPUR_VEC  = 16'h0010,
  localparam int           NSLOT     = LEVELS * SLOTS,
  localparam int           LW        = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cpuBoundary,
  input  logic             rtiReq,
  input  logic [DW-1:0]    cpuPc,
  input  logic [DW-1:0]    cpuPsw,
  input  logic [DW-1:0]    cpuSp,
  input  logic [NSLOT-1:0] slotReq,
  output logic [NSLOT-1:0] slotGrant,
  input  logic             vecValid,
  input  logic [DW-1:0]    vecAddr,
  output logic             memReq,
  output logic             memWrite,
  output logic [DW-1:0]    memAddr,
  output logic [DW-1:0]    memWdata,
  input  logic             memAck,
  input  logic [DW-1:0]    memRdata,
  output logic             ctxLoad,
  output logic [DW-1:0]    newPc,
  output logic [DW-1:0]    newPsw,
  output logic [DW-1:0]    newSp,
  output logic             spuriousEvt,
  output logic             busy
);
  strobe_t       stb;
  logic          anyEligible, timeoutHit, grantActive;
  logic [LW-1:0] winLevel, grantLevel;

  vip_arbiter #(
    .LEVELS(LEVELS), .SLOTS(SLOTS), .PRIO_W(PRIO_W), .PRIO_BASE(PRIO_BASE)
  ) u_arb (
    .slotReq    (slotReq),
    .pswPrio    (cpuPsw[PRIO_LSB +: PRIO_W]),
    .anyEligible(anyEligible),
    .winLevel   (winLevel)
  );

  vip_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .cpuBoundary(cpuBoundary),
    .rtiReq     (rtiReq),
    .anyEligible(anyEligible),
    .vecValid   (vecValid),
    .timeoutHit (timeoutHit),
    .memAck     (memAck),
    .stb        (stb),
    .grantActive(grantActive),
    .ctxLoad    (ctxLoad),
    .busy       (busy)
  );

  vip_dpath #(
    .DW(DW), .LW(LW), .TIMEOUT(TIMEOUT), .SPUR_VEC(SPUR_VEC)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .cpuPc     (cpuPc),
    .cpuPsw    (cpuPsw),
    .cpuSp     (cpuSp),
    .winLevel  (winLevel),
    .vecAddr   (vecAddr),
    .memRdata  (memRdata),
    .grantLevel(grantLevel),
    .timeoutHit(timeoutHit),
    .spurFlag  (spuriousEvt),
    .memReq    (memReq),
    .memWrite  (memWrite),
    .memAddr   (memAddr),
    .memWdata  (memWdata),
    .newPc     (newPc),
    .newPsw    (newPsw),
    .newSp     (newSp)
  );

  for (genvar l = 0; l < LEVELS; l++) begin : g_chain
    logic levelGrant;
    assign levelGrant = grantActive && (grantLevel == LW'(l));
    vip_chain #(.SLOTS(SLOTS)) u_chain (
      .grantIn (levelGrant),
      .reqIn   (slotReq[l*SLOTS +: SLOTS]),
      .grantOut(slotGrant[l*SLOTS +: SLOTS])
    );
  end
endmodule

// File: rtl/vip_checker.sv
module vip_checker #(
  parameter int DW    = 16,
  parameter int NSLOT = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic [NSLOT-1:0] slotReq,
  input logic [NSLOT-1:0] slotGrant,
  input logic             busy,
  input logic             ctxLoad,
  input logic             memReq,
  input logic             memAck,
  input logic             memWrite,
  input logic [DW-1:0]    memAddr,
  input logic [DW-1:0]    memWdata,
  input logic             spuriousEvt
);
  assert_one_grant_R3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(slotGrant));

  assert_grant_to_requester_R3: assert property (@(posedge clk) disable iff (!rstN)
    (slotGrant & ~slotReq) == '0);

  assert_grant_while_busy_R4: assert property (@(posedge clk) disable iff (!rstN)
    (|slotGrant) |-> busy);

  assert_load_pulse_R6: assert property (@(posedge clk) disable iff (!rstN)
    ctxLoad |=> !ctxLoad);

  assert_mem_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(memAddr) && $stable(memWrite)
                             && $stable(memWdata)));

  assert_spur_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    spuriousEvt |-> (busy && memReq && memWrite));

  assert_spur_single_R7: assert property (@(posedge clk) disable iff (!rstN)
    spuriousEvt |=> !spuriousEvt);
endmodule

bind vec_irq_unit vip_checker #(.DW(DW), .NSLOT(NSLOT)) u_vipChk (
  .clk        (clk),
  .rstN       (rstN),
  .slotReq    (slotReq),
  .slotGrant  (slotGrant),
  .busy       (busy),
  .ctxLoad    (ctxLoad),
  .memReq     (memReq),
  .memAck     (memAck),
  .memWrite   (memWrite),
  .memAddr    (memAddr),
  .memWdata   (memWdata),
  .spuriousEvt(spuriousEvt)
);

// File: tb/test_vec_irq_unit.sv
module test_vec_irq_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cpuBoundary = 1'b1;
  logic        rtiReq = 1'b0;
  logic [15:0] cpuPc = '0, cpuPsw = '0, cpuSp = '0;
  logic [15:0] slotReq = '0;
  logic [15:0] slotGrant;
  logic        vecValid = 1'b0;
  logic [15:0] vecAddr = '0;
  logic        memReq, memWrite, memAck = 1'b0;
  logic [15:0] memAddr, memWdata, memRdata = '0;
  logic        ctxLoad, spuriousEvt, busy;
  logic [15:0] newPc, newPsw, newSp;

  always #4 clk = ~clk;

  vec_irq_unit i_vec_irq_unit (
    .clk(clk), .rstN(rstN), .cpuBoundary(cpuBoundary), .rtiReq(rtiReq),
    .cpuPc(cpuPc), .cpuPsw(cpuPsw), .cpuSp(cpuSp),
    .slotReq(slotReq), .slotGrant(slotGrant),
    .vecValid(vecValid), .vecAddr(vecAddr),
    .memReq(memReq), .memWrite(memWrite), .memAddr(memAddr), .memWdata(memWdata),
    .memAck(memAck), .memRdata(memRdata),
    .ctxLoad(ctxLoad), .newPc(newPc), .newPsw(newPsw), .newSp(newSp),
    .spuriousEvt(spuriousEvt), .busy(busy)
  );

  int total = 0, bad = 0;
  int loadCount = 0, grantCycles = 0, spurCount = 0;
  int respondIdx = -1;
  logic [15:0] respondVec = '0;
  logic        manualVec = 1'b0;
  logic [15:0] mem [0:255];

  typedef struct packed {
    logic [15:0] pc;
    logic [15:0] psw;
    logic [15:0] sp;
    logic [3:0]  kind; // 0 entry R6, 1 return R8, 2 spurious R7, 3 retaken R9
  } exp_t;
  exp_t expQ[$];

  task automatic check(input logic ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic expect_ctx(input logic [15:0] pc, input logic [15:0] psw,
                            input logic [15:0] sp, input logic [3:0] kind);
    exp_t e;
    e.pc = pc; e.psw = psw; e.sp = sp; e.kind = kind;
    expQ.push_back(e);
  endtask

  task automatic wait_loads(input int n);
    while (loadCount < n) @(negedge clk);
  endtask

  task automatic pulse_rti();
    @(negedge clk) rtiReq = 1'b1;
    @(negedge clk) rtiReq = 1'b0;
  endtask

  task automatic set_cpu(input logic [15:0] pc, input logic [15:0] psw,
                         input logic [15:0] sp);
    cpuPc = pc; cpuPsw = psw; cpuSp = sp;
  endtask

  // memory model: acknowledges every other cycle
  initial forever begin
    @(negedge clk);
    if (memAck) memAck = 1'b0;
    else if (memReq) begin
      if (memWrite) mem[memAddr[8:1]] = memWdata;
      else          memRdata = mem[memAddr[8:1]];
      memAck = 1'b1;
    end
  end

  // device model: the chosen slot answers when its grant arrives
  initial forever begin
    @(negedge clk);
    if (manualVec) begin
      vecValid = 1'b1; vecAddr = 16'h0040;
    end else if (respondIdx >= 0 && slotGrant[respondIdx]) begin
      vecValid = 1'b1; vecAddr = respondVec;
    end else begin
      vecValid = 1'b0;
    end
  end

  // monitor: scoreboard compare on each context load, acts as the processor
  initial forever begin
    @(negedge clk);
    if (slotGrant[4]) grantCycles++;
    if (spuriousEvt)  spurCount++;
    if (ctxLoad) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R6 unexpected load", {16'h0, newPc}, 32'h0);
      end else begin
        exp_t e;
        string tag;
        e = expQ.pop_front();
        case (e.kind)
          4'd0: tag = "R6 entry";
          4'd1: tag = "R8 return";
          4'd2: tag = "R7 spurious entry";
          default: tag = "R9 retaken request";
        endcase
        check(newPc == e.pc,   {tag, " pc"},  {16'h0, newPc},  {16'h0, e.pc});
        check(newPsw == e.psw, {tag, " psw"}, {16'h0, newPsw}, {16'h0, e.psw});
        check(newSp == e.sp,   {tag, " sp"},  {16'h0, newSp},  {16'h0, e.sp});
      end
      cpuPc = newPc; cpuPsw = newPsw; cpuSp = newSp;
      loadCount++;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 16'h0;
    mem[8'h08] = 16'h0A10; mem[8'h09] = 16'h00E0; // vector 0x0010
    mem[8'h20] = 16'h0A40; mem[8'h21] = 16'h00E0; // vector 0x0040
    mem[8'h28] = 16'h0A50; mem[8'h29] = 16'h00E0; // vector 0x0050
    mem[8'h30] = 16'h0A60; mem[8'h31] = 16'h00E0; // vector 0x0060
    set_cpu(16'h1000, 16'h0000, 16'h0100);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // reset state
    check(busy == 1'b0 && ctxLoad == 1'b0, "R1 reset idle", {30'h0, busy, ctxLoad}, 32'h0);
    check(slotGrant == 16'h0 && memReq == 1'b0, "R3 reset no grant",
          {15'h0, memReq, slotGrant}, 32'h0);

    // R4: vector strobe with no grant open has no effect
    manualVec = 1'b1;
    repeat (4) @(negedge clk);
    check(busy == 1'b0 && memReq == 1'b0, "R4 stray vector ignored",
          {30'h0, busy, memReq}, 32'h0);
    manualVec = 1'b0;
    @(negedge clk);
    check(loadCount == 0, "R4 stray vector no load", loadCount, 0);

    // R3/R5/R6: slots 9 and 10 on level 2, nearest requester wins
    respondIdx = 9; respondVec = 16'h0043; // low bits must be dropped (R4)
    expect_ctx(16'h0A40, 16'h00E0, 16'h00FC, 4'd0);
    slotReq = 16'h0600;
    @(negedge clk);
    check(slotGrant == 16'h0200, "R3 chain nearest slot", {16'h0, slotGrant}, 32'h0200);
    wait_loads(1);
    check(mem[8'h7F] == 16'h0000, "R5 psw at sp-2", {16'h0, mem[8'h7F]}, 32'h0);
    check(mem[8'h7E] == 16'h1000, "R5 pc at sp-4", {16'h0, mem[8'h7E]}, 32'h1000);

    // R8 then R9: return drops priority, held request is taken again
    expect_ctx(16'h1000, 16'h0000, 16'h0100, 4'd1);
    expect_ctx(16'h0A40, 16'h00E0, 16'h00FC, 4'd3);
    pulse_rti();
    wait_loads(3);
    slotReq[9] = 1'b0;
    respondIdx = 10; respondVec = 16'h0050;
    expect_ctx(16'h1000, 16'h0000, 16'h0100, 4'd1);
    expect_ctx(16'h0A50, 16'h00E0, 16'h00FC, 4'd3);
    pulse_rti();
    wait_loads(5);
    slotReq = '0;
    expect_ctx(16'h1000, 16'h0000, 16'h0100, 4'd1);
    pulse_rti();
    wait_loads(6);

    // R1 strict comparison, then R2 higher level taken
    @(negedge clk);
    set_cpu(16'h2000, 16'h00C0, 16'h0180);
    slotReq = 16'h0100; // level 2 = priority 6, equal to status
    repeat (6) @(negedge clk);
    check(busy == 1'b0 && slotGrant == 16'h0, "R1 equal priority blocked",
          {15'h0, busy, slotGrant}, 32'h0);
    respondIdx = 12; respondVec = 16'h0060;
    expect_ctx(16'h0A60, 16'h00E0, 16'h017C, 4'd0);
    slotReq = 16'h1100;
    @(negedge clk);
    check(slotGrant == 16'h1000, "R2 level 3 over blocked level 2",
          {16'h0, slotGrant}, 32'h1000);
    wait_loads(7);
    slotReq = '0;
    expect_ctx(16'h2000, 16'h00C0, 16'h0180, 4'd1);
    pulse_rti();
    wait_loads(8);

    // R2: both levels eligible, the higher one wins
    @(negedge clk);
    set_cpu(16'h3000, 16'h0000, 16'h0180);
    respondIdx = 6; respondVec = 16'h0050;
    expect_ctx(16'h0A50, 16'h00E0, 16'h017C, 4'd0);
    slotReq = 16'h0042;
    @(negedge clk);
    check(slotGrant == 16'h0040, "R2 highest eligible level", {16'h0, slotGrant}, 32'h0040);
    wait_loads(9);
    slotReq = '0;
    expect_ctx(16'h3000, 16'h0000, 16'h0180, 4'd1);
    pulse_rti();
    wait_loads(10);

    // R1 boundary gate, then R7 timeout into spurious vector
    @(negedge clk);
    respondIdx = -1;
    cpuBoundary = 1'b0;
    slotReq = 16'h0010;
    repeat (5) @(negedge clk);
    check(busy == 1'b0 && slotGrant == 16'h0, "R1 boundary low blocks",
          {15'h0, busy, slotGrant}, 32'h0);
    grantCycles = 0; spurCount = 0;
    expect_ctx(16'h0A10, 16'h00E0, 16'h017C, 4'd2);
    cpuBoundary = 1'b1;
    wait_loads(11);
    check(grantCycles == 64, "R7 grant window length", grantCycles, 64);
    check(spurCount == 1, "R7 spurious pulse count", spurCount, 1);
    slotReq = '0;
    repeat (4) @(negedge clk);
    check(expQ.size() == 0, "R6 all loads seen", expQ.size(), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule